// File: doc/BRIEF.md
# Byte-Lane Static Memory Model with Dual Chip Selects

This block is a clocked functional model of a word-wide static memory with two independent byte lanes. Two chip selects of opposite polarity, an output enable, a write enable and one active-low enable per byte lane are sampled on every rising clock edge. The decoded controls pick one of four modes: deselect, read, output-disabled or write. The bidirectional data bus of a discrete part is split into a write-data input, a read-data output and one drive flag per lane. An integrating chip can place the tri-state buffers itself, or it can use the flags to steer its own datapath.

Write takes priority over the output enable. A lane that is not enabled is never stored and never driven. When both lane enables are inactive the part behaves exactly as if it were deselected. Read data, lane drive flags and the standby flag are registered, so each reflects the controls that were sampled one edge earlier. Depth and width are parameters. With the default address width of 10 the model is small enough to elaborate anywhere. An address width of 16 gives the full 64K-word array.

Top module: `sram_bytelane`

## Requirements
- R1: The memory holds 2**ADDR_W words of DATA_W bits (default 1024 x 16). A word written with both lanes enabled (lane_n=2'b00) reads back unchanged at the same address.
- R2: The device is selected only when cs1_n=0 and cs2=1. Any sample with cs1_n=1 or cs2=0 stores nothing and drives no lane, whatever the other inputs are.
- R3: A sample with lane_n=2'b11 is treated as a deselect even when both chip selects are active. It stores nothing and drives nothing.
- R4: Read mode is selected, we_n=1 and oe_n=0. Lane 0 (rdata[DATA_W/2-1:0]) is driven only if lane_n[0]=0, and lane 1 (upper half) only if lane_n[1]=0. A driven lane has rdrive[i]=1 and carries the stored bits.
- R5: Output-disabled mode is selected, we_n=1 and oe_n=1. rdrive=2'b00 whatever lane_n is, and the contents stay unchanged.
- R6: Write mode is selected and we_n=0, whatever oe_n is. Only the lanes with lane_n[i]=0 take the corresponding wdata bits. The other lane keeps its old value.
- R7: After any write sample, rdrive=2'b00, even when oe_n=0.
- R8: A sample stores data only when we_n=0, the chip is selected and at least one lane enable is low. If any one of these is missing, the contents stay unchanged.
- R9: standby is 1 after any deselect sample (cs1_n=1, cs2=0 or lane_n=2'b11) and 0 after any selected sample.
- R10: rdata, rdrive and standby change only at the rising edge that samples the controls, and reflect that sample. An undriven lane shows all zeros on rdata.
- R11: While rst_n=0, rdata=0, rdrive=2'b00 and standby=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset of output registers |
| cs1_n | input | 1 | Active-low chip select |
| cs2 | input | 1 | Active-high chip select |
| we_n | input | 1 | Active-low write enable |
| oe_n | input | 1 | Active-low output enable |
| lane_n | input | 2 | Active-low byte lane enables, bit 0 low half, bit 1 high half |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data, zero on undriven lanes |
| rdrive | output | 2 | Registered per-lane output drive flags |
| standby | output | 1 | Registered deselect status |

## Verification
Every address is first filled with full-word writes. A long random run then mixes all control combinations, biased toward a selected chip, so that read, output-disabled, write and every kind of deselect are visited against a reference copy of the memory. Directed cases separate the corner cases the random run may blur. A write with one lane enabled shows that the other lane is kept. A write with oe_n low must not drive. A write under each deselect cause and under both lane enables high must leave the data untouched when it is read back. A read with one lane enabled shows that the undriven half is zeroed.

// File: rtl/sram_bl_pkg.sv
package sram_bl_pkg;
   localparam int unsigned LANES = 2;

   typedef enum logic [1:0] {
      MD_DESEL = 2'd0,
      MD_READ  = 2'd1,
      MD_HIZ   = 2'd2,
      MD_WRITE = 2'd3
   } sram_mode_e;
endpackage

// File: rtl/sram_mode_dec.sv
module sram_mode_dec
   import sram_bl_pkg::*;
#(
   parameter int unsigned NLANE = LANES
) (
   input  logic             cs1_n,
   input  logic             cs2,
   input  logic             we_n,
   input  logic             oe_n,
   input  logic [NLANE-1:0] lane_n,
   output sram_mode_e       mode,
   output logic             desel
);
   logic chip_on;
   logic any_lane;

   always_comb begin
      chip_on  = !cs1_n && cs2;
      any_lane = !(&lane_n);
      desel    = !(chip_on && any_lane);
      if (desel)      mode = MD_DESEL;
      else if (!we_n) mode = MD_WRITE;
      else if (!oe_n) mode = MD_READ;
      else            mode = MD_HIZ;
   end
endmodule

// File: rtl/sram_lane_store.sv
module sram_lane_store #(
   parameter int unsigned ADDR_W = 10,
   parameter int unsigned LANE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [LANE_W-1:0] wdata,
   output logic [LANE_W-1:0] rdata,
   output logic              drive
);
   localparam int unsigned DEPTH = 1 << ADDR_W;

   logic [LANE_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) mem[addr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata <= '0;
         drive <= 1'b0;
      end else begin
         drive <= rd_en;
         rdata <= rd_en ? mem[addr] : '0;
      end
   end

   a_r8_no_rw_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && rd_en));
endmodule

// File: rtl/sram_bytelane.sv
module sram_bytelane
   import sram_bl_pkg::*;
#(
   parameter int unsigned ADDR_W = 10,
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs1_n,
   input  logic              cs2,
   input  logic              we_n,
   input  logic              oe_n,
   input  logic [1:0]        lane_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic [1:0]        rdrive,
   output logic              standby
);
   localparam int unsigned LANE_W = DATA_W / LANES;

   if (DATA_W % LANES != 0 || DATA_W < LANES) begin : g_bad_width
      $error("sram_bytelane: DATA_W must split evenly into lanes");
   end
   if (ADDR_W < 1 || ADDR_W > 20) begin : g_bad_addr
      $error("sram_bytelane: ADDR_W out of range");
   end

   sram_mode_e mode;
   logic       desel;

   sram_mode_dec #(.NLANE(LANES)) i_dec (
      .cs1_n (cs1_n),
      .cs2   (cs2),
      .we_n  (we_n),
      .oe_n  (oe_n),
      .lane_n(lane_n),
      .mode  (mode),
      .desel (desel)
   );

   for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
      logic lane_wr;
      logic lane_rd;
      assign lane_wr = (mode == MD_WRITE) && !lane_n[gi];
      assign lane_rd = (mode == MD_READ)  && !lane_n[gi];

      sram_lane_store #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) i_store (
         .clk   (clk),
         .rst_n (rst_n),
         .wr_en (lane_wr),
         .rd_en (lane_rd),
         .addr  (addr),
         .wdata (wdata[gi*LANE_W +: LANE_W]),
         .rdata (rdata[gi*LANE_W +: LANE_W]),
         .drive (rdrive[gi])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) standby <= 1'b1;
      else        standby <= desel;
   end

   // Port-level relations across one sampling edge
   a_r2_unselected: assert property (@(posedge clk) disable iff (!rst_n)
      (cs1_n || !cs2) |=> (standby && rdrive == 2'b00));
   a_r3_lanes_off: assert property (@(posedge clk) disable iff (!rst_n)
      (lane_n == 2'b11) |=> (standby && rdrive == 2'b00));
   a_r4_lane_match: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs1_n && cs2 && we_n && !oe_n && lane_n != 2'b11) |=>
      (rdrive == ~$past(lane_n) && !standby));
   a_r5_oe_high: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs1_n && cs2 && we_n && oe_n) |=> (rdrive == 2'b00));
   a_r7_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs1_n && cs2 && !we_n) |=> (rdrive == 2'b00));
   a_r10_zero_lane0: assert property (@(posedge clk) disable iff (!rst_n)
      !rdrive[0] |-> (rdata[LANE_W-1:0] == '0));
   a_r10_zero_lane1: assert property (@(posedge clk) disable iff (!rst_n)
      !rdrive[1] |-> (rdata[DATA_W-1:LANE_W] == '0));
endmodule

// File: tb/test_sram_bytelane.sv
`timescale 1ns/1ps
module test_sram_bytelane;
   localparam int unsigned ADDR_W = 10;
   localparam int unsigned DATA_W = 16;
   localparam int unsigned DEPTH  = 1 << ADDR_W;
   localparam int unsigned LW     = DATA_W / 2;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cs1_n = 1'b1, cs2 = 1'b0, we_n = 1'b1, oe_n = 1'b1;
   logic [1:0]        lane_n = 2'b11;
   logic [ADDR_W-1:0] addr = '0;
   logic [DATA_W-1:0] wdata = '0;
   logic [DATA_W-1:0] rdata;
   logic [1:0]        rdrive;
   logic              standby;

   int checks = 0;
   int errors = 0;
   logic [DATA_W-1:0] ref_mem [DEPTH];

   sram_bytelane #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_sram_bytelane (
      .clk(clk), .rst_n(rst_n), .cs1_n(cs1_n), .cs2(cs2), .we_n(we_n),
      .oe_n(oe_n), .lane_n(lane_n), .addr(addr), .wdata(wdata),
      .rdata(rdata), .rdrive(rdrive), .standby(standby)
   );

   always #2.5 clk = ~clk;

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   function automatic logic is_sel(logic c1, logic c2, logic [1:0] ln);
      return !c1 && c2 && (ln != 2'b11);
   endfunction

   // One sampled cycle: drive, wait for edge, compare, update reference
   task automatic cyc(input logic c1, input logic c2, input logic w, input logic o,
                      input logic [1:0] ln, input logic [ADDR_W-1:0] a,
                      input logic [DATA_W-1:0] d, input string dtag);
      logic sel, wr, rd;
      logic [1:0] e_drv;
      logic [DATA_W-1:0] e_dat;
      string ptag;
      @(negedge clk);
      cs1_n = c1; cs2 = c2; we_n = w; oe_n = o; lane_n = ln; addr = a; wdata = d;
      sel = is_sel(c1, c2, ln);
      wr  = sel && !w;
      rd  = sel && w && !o;
      e_drv = rd ? ~ln : 2'b00;
      e_dat = '0;
      if (rd && !ln[0]) e_dat[LW-1:0]      = ref_mem[a][LW-1:0];
      if (rd && !ln[1]) e_dat[DATA_W-1:LW] = ref_mem[a][DATA_W-1:LW];
      if (!(!c1 && c2))     ptag = "R2";
      else if (ln == 2'b11) ptag = "R3";
      else if (wr)          ptag = "R7";
      else if (rd)          ptag = "R4";
      else                  ptag = "R5";
      @(posedge clk);
      #1;
      chk(ptag, 32'(rdrive), 32'(e_drv));
      chk(rd ? dtag : "R10", 32'(rdata), 32'(e_dat));
      chk("R9", 32'(standby), 32'(!sel));
      if (wr && !ln[0]) ref_mem[a][LW-1:0]      = d[LW-1:0];
      if (wr && !ln[1]) ref_mem[a][DATA_W-1:LW] = d[DATA_W-1:LW];
   endtask

   initial begin
      #(5.0 * 150000);
      errors++;
      $display("FAIL R10: watchdog expired, got running expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd2024));
      for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
      // R11: reset state
      #12;
      chk("R11", 32'(rdata), 32'h0);
      chk("R11", 32'(rdrive), 32'h0);
      chk("R11", 32'(standby), 32'h1);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: fill every word with full-width writes
      for (int i = 0; i < DEPTH; i++)
         cyc(1'b0, 1'b1, 1'b0, 1'b1, 2'b00, ADDR_W'(i), DATA_W'($urandom), "R1");

      // R1: full-word readback
      cyc(1'b0, 1'b1, 1'b1, 1'b0, 2'b00, 10'd5, '0, "R1");

      // R6: write only the high lane with oe_n low (R7), then read both lanes
      cyc(1'b0, 1'b1, 1'b0, 1'b0, 2'b01, 10'd7, 16'hA55A, "R6");
      cyc(1'b0, 1'b1, 1'b1, 1'b0, 2'b00, 10'd7, '0, "R6");
      // R6: write only the low lane
      cyc(1'b0, 1'b1, 1'b0, 1'b1, 2'b10, 10'd7, 16'h3CC3, "R6");
      cyc(1'b0, 1'b1, 1'b1, 1'b0, 2'b00, 10'd7, '0, "R6");

      // R2/R3/R8: write attempts with each missing condition, then read back
      cyc(1'b1, 1'b1, 1'b0, 1'b0, 2'b00, 10'd9, 16'hDEAD, "R8");
      cyc(1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 10'd9, 16'hBEEF, "R8");
      cyc(1'b0, 1'b1, 1'b0, 1'b0, 2'b11, 10'd9, 16'hF00D, "R8");
      cyc(1'b0, 1'b1, 1'b1, 1'b1, 2'b00, 10'd9, 16'hCAFE, "R5");
      cyc(1'b0, 1'b1, 1'b1, 1'b0, 2'b00, 10'd9, '0, "R8");

      // R4/R10: single-lane reads, other half must be zero
      cyc(1'b0, 1'b1, 1'b1, 1'b0, 2'b10, 10'd7, '0, "R4");
      cyc(1'b0, 1'b1, 1'b1, 1'b0, 2'b01, 10'd7, '0, "R4");
      // R5: output disabled with each lane pattern
      for (int k = 0; k < 4; k++)
         cyc(1'b0, 1'b1, 1'b1, 1'b1, 2'(k), 10'd7, '0, "R5");

      // Random mix, biased toward a selected chip
      for (int n = 0; n < 4000; n++)
         cyc(($urandom % 8) == 0, ($urandom % 8) != 0, 1'($urandom), 1'($urandom),
             2'($urandom), ADDR_W'($urandom % DEPTH), DATA_W'($urandom), "R1");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule